// File: doc/BRIEF.md
# Priority Round-Robin Arbiter with Aging

This block picks one winner per cycle from a set of requesters. Each requester raises a request flag and supplies a 3-bit urgency level from 0 to 7, where 7 is the most urgent. Among the active requests, the most urgent level wins. When several requests share that level, a rotating pointer chooses among them, so equal requesters take turns.

The block also guards against starvation. Each lane has a counter of the cycles its request has stayed pending without a grant. Once that count reaches a threshold set at run time, the request is marked aged. An aged request beats every non-aged request, whatever the urgency levels. The grant is combinational from the current inputs and the registered state. It can sit in front of a network switch allocator or a memory transaction scheduler.

Top module: `prio_age_arb`

## Requirements
- R1: `grant_o` has at most one bit set. That bit is always a lane whose request is active. With no active request, `grant_o` is zero.
- R2: When no request is aged, the grant goes to a request carrying the largest urgency value among active requests (values 0..7, 7 most urgent), wherever the rotating pointer stands.
- R3: Among candidates of equal standing, the winner is the first candidate found scanning upward from the pointer and wrapping past lane N_REQ-1 to lane 0. After any grant the pointer moves to the lane just above the winner, wrapping. Without a grant it holds.
- R4: A lane's wait count is the number of consecutive cycles its request has been active without a grant. The request is aged when that count is at least `age_limit_i`. If any request is aged, the grant goes to an aged request.
- R5: Among several aged requests, the winner is picked by the rotating pointer alone, ignoring urgency values.
- R6: A lane's wait count returns to zero in the cycle after the lane is granted or its request is low.
- R7: The wait count saturates at its all-ones value and does not wrap while the request keeps waiting.
- R8: Reset (active-low `rst_n`) sets the pointer to lane 0 and clears all wait counts. The first grant after reset among equal requests therefore goes to lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_REQ | Request flag per lane |
| prio_i | input | 3*N_REQ | Urgency per lane, lane k in bits [3k+2:3k] |
| age_limit_i | input | AGE_W | Wait threshold in cycles for ageing |
| grant_o | output | N_REQ | One-hot or zero grant |

## Verification
The bench checks the pointer wrap among a subset of equal-urgency lanes. A design that scans from lane 0 every time, or that fails to wrap, grants the wrong lane in that case. A low-urgency lane is held against a more urgent one until it ages, and the bench requires it to win in exactly the cycle its count meets the threshold; an off-by-one compare moves that win by one cycle. A request that drops for one cycle must restart its count, or it ages early. Two lanes are made to age together so that the second is served only if its count saturates rather than wrapping back to zero. A zero threshold must turn the block into a plain rotation that ignores urgency.

// File: rtl/prio_arb_pkg.sv
// Shared definitions for the priority/aging arbiter.
// Assumes urgency is an unsigned level where a larger value is more urgent.
package prio_arb_pkg;
    localparam int PRIO_W = 3;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/arb_wait_ctr.sv
// Per-lane wait counter: counts cycles a request stays pending without a grant,
// saturates at all-ones, and flags the request as aged once it meets the limit.
// Assumes gnt_i comes from the same arbiter the count feeds.
module arb_wait_ctr #(
    parameter int AGE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             gnt_i,
    input  logic [AGE_W-1:0] limit_i,
    output logic [AGE_W-1:0] cnt_o,
    output logic             aged_o
);
    localparam logic [AGE_W-1:0] CNT_MAX = '1;

    logic [AGE_W-1:0] cnt_q;

    // Count waiting cycles; clear on grant or idle; hold at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!req_i || gnt_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + AGE_W'(1);
        end
    end

    // Aged flag from the registered count and the live request.
    always_comb begin
        aged_o = req_i && (cnt_q >= limit_i);
        cnt_o  = cnt_q;
    end
endmodule

// File: rtl/arb_prio_filter.sv
// Finds the largest urgency among active requests and marks every active lane
// that carries it. Purely combinational; yields an empty mask with no requests.
module arb_prio_filter #(
    parameter int N_REQ = 4
) (
    input  logic [N_REQ-1:0]                       req_i,
    input  logic [N_REQ*prio_arb_pkg::PRIO_W-1:0]  prio_i,
    output logic [N_REQ-1:0]                       top_mask_o
);
    import prio_arb_pkg::*;

    prio_t top_lvl;

    // Scan for the highest level carried by an active request.
    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > top_lvl)) begin
                top_lvl = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // Keep only active lanes sitting at that level.
    always_comb begin
        for (int i = 0; i < N_REQ; i++) begin
            top_mask_o[i] = req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] == top_lvl);
        end
    end
endmodule

// File: rtl/arb_rr_pick.sv
// Rotating picker: returns the first set lane of the candidate mask scanning up
// from the pointer with wrap-around, as a one-hot vector and an index.
module arb_rr_pick #(
    parameter int N_REQ = 4,
    parameter int PTR_W = 2
) (
    input  logic [N_REQ-1:0] mask_i,
    input  logic [PTR_W-1:0] ptr_i,
    output logic [N_REQ-1:0] gnt_o,
    output logic [PTR_W-1:0] idx_o,
    output logic             any_o
);
    // Cyclic scan from the pointer, first hit wins.
    always_comb begin
        int  pos;
        logic found;
        gnt_o = '0;
        idx_o = '0;
        found = 1'b0;
        for (int i = 0; i < N_REQ; i++) begin
            pos = int'(ptr_i) + i;
            if (pos >= N_REQ) pos = pos - N_REQ;
            if (!found && mask_i[pos]) begin
                found      = 1'b1;
                gnt_o[pos] = 1'b1;
                idx_o      = PTR_W'(pos);
            end
        end
        any_o = found;
    end
endmodule

// File: rtl/prio_age_arb.sv
// Priority arbiter with round-robin tie-break and an aging override.
// Aged requests (waited >= age_limit_i cycles) are served first, by rotation;
// otherwise the most urgent level wins, with rotation among equals.
// Grant is combinational; the pointer and wait counts are registered.
// Assumes N_REQ >= 2.
module prio_age_arb #(
    parameter int N_REQ = 4,
    parameter int AGE_W = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [N_REQ-1:0]                      req_i,
    input  logic [N_REQ*prio_arb_pkg::PRIO_W-1:0] prio_i,
    input  logic [AGE_W-1:0]                      age_limit_i,
    output logic [N_REQ-1:0]                      grant_o
);
    localparam int PTR_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;
    localparam logic [PTR_W-1:0] LAST_LANE = PTR_W'(N_REQ - 1);

    logic [N_REQ-1:0]       aged;
    logic [N_REQ*AGE_W-1:0] wait_cnt;
    logic [N_REQ-1:0]       top_mask;
    logic [N_REQ-1:0]       cand;
    logic [PTR_W-1:0]       ptr_q;
    logic [PTR_W-1:0]       win_idx;
    logic                   win_any;

    // One wait counter per lane.
    for (genvar g = 0; g < N_REQ; g++) begin : g_lane
        arb_wait_ctr #(.AGE_W(AGE_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (req_i[g]),
            .gnt_i   (grant_o[g]),
            .limit_i (age_limit_i),
            .cnt_o   (wait_cnt[g*AGE_W +: AGE_W]),
            .aged_o  (aged[g])
        );
    end

    arb_prio_filter #(.N_REQ(N_REQ)) u_filter (
        .req_i      (req_i),
        .prio_i     (prio_i),
        .top_mask_o (top_mask)
    );

    // Aged lanes override urgency order entirely.
    always_comb begin
        cand = (|aged) ? aged : top_mask;
    end

    arb_rr_pick #(.N_REQ(N_REQ), .PTR_W(PTR_W)) u_pick (
        .mask_i (cand),
        .ptr_i  (ptr_q),
        .gnt_o  (grant_o),
        .idx_o  (win_idx),
        .any_o  (win_any)
    );

    // Move the pointer just past the winner, only when a grant is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (win_any) begin
            ptr_q <= (win_idx == LAST_LANE) ? '0 : win_idx + PTR_W'(1);
        end
    end
endmodule

// File: rtl/prio_age_arb_chk.sv
// Assertion checker for prio_age_arb, attached by bind below.
// Observes ports plus the aged flags and wait counts of the arbiter.
module prio_age_arb_chk #(
    parameter int N_REQ = 4,
    parameter int AGE_W = 16
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic [N_REQ-1:0]                      req,
    input logic [N_REQ*prio_arb_pkg::PRIO_W-1:0] prio,
    input logic [N_REQ-1:0]                      grant,
    input logic [N_REQ-1:0]                      aged,
    input logic [N_REQ*AGE_W-1:0]                wait_cnt
);
    localparam int PW = prio_arb_pkg::PRIO_W;
    localparam logic [AGE_W-1:0] CNT_MAX = '1;

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r1_grant_req: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (grant == '0));

    a_r4_aged_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|aged) |-> ((grant & aged) != '0));

    for (genvar i = 0; i < N_REQ; i++) begin : g_i
        for (genvar j = 0; j < N_REQ; j++) begin : g_j
            a_r2_prio_order: assert property (@(posedge clk) disable iff (!rst_n)
                ((aged == '0) && grant[i] && req[j]) |->
                (prio[i*PW +: PW] >= prio[j*PW +: PW]));
        end

        a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] || !req[i]) |=> (wait_cnt[i*AGE_W +: AGE_W] == '0));

        a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
            ((wait_cnt[i*AGE_W +: AGE_W] == CNT_MAX) && req[i] && !grant[i]) |=>
            (!req[i] || (wait_cnt[i*AGE_W +: AGE_W] == CNT_MAX)) );
    end
endmodule

bind prio_age_arb prio_age_arb_chk #(.N_REQ(N_REQ), .AGE_W(AGE_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_i),
    .prio     (prio_i),
    .grant    (grant_o),
    .aged     (aged),
    .wait_cnt (wait_cnt)
);

// File: tb/test_prio_age_arb.sv
`timescale 1ns/100ps
module test_prio_age_arb;
    localparam int N = 4;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [3*N-1:0] prio = '0;
    logic [AW-1:0] limit = '1;
    logic [N-1:0]  grant;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    prio_age_arb #(.N_REQ(N), .AGE_W(AW)) i_prio_age_arb (
        .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio),
        .age_limit_i(limit), .grant_o(grant)
    );

    // Row: {kind[1:0], req[3:0], prio3..prio0 (3 bits each), expected[3:0]}
    localparam logic [21:0] VEC [12] = '{
        {2'd0, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0, 4'b0000},
        {2'd3, 4'b1111, 3'd2, 3'd2, 3'd2, 3'd2, 4'b0001},
        {2'd2, 4'b1111, 3'd2, 3'd2, 3'd2, 3'd2, 4'b0010},
        {2'd2, 4'b1111, 3'd2, 3'd2, 3'd2, 3'd2, 4'b0100},
        {2'd2, 4'b1111, 3'd2, 3'd2, 3'd2, 3'd2, 4'b1000},
        {2'd1, 4'b1111, 3'd3, 3'd5, 3'd5, 3'd1, 4'b0010},
        {2'd2, 4'b1111, 3'd3, 3'd5, 3'd5, 3'd1, 4'b0100},
        {2'd2, 4'b1111, 3'd3, 3'd5, 3'd5, 3'd1, 4'b0010},
        {2'd0, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd0, 4'b0001},
        {2'd1, 4'b1001, 3'd6, 3'd0, 3'd0, 3'd7, 4'b0001},
        {2'd1, 4'b1001, 3'd7, 3'd0, 3'd0, 3'd0, 4'b1000},
        {2'd2, 4'b1010, 3'd7, 3'd7, 3'd7, 3'd7, 4'b0010}
    };

    task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: grant=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic [AW-1:0] lim);
        @(negedge clk);
        rst_n = 1'b0;
        req   = '0;
        limit = lim;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Apply inputs after a falling edge, check grant 1 ns later.
    task automatic step(input logic [N-1:0] r, input logic [3*N-1:0] p,
                        input logic [N-1:0] exp, input string tag);
        @(negedge clk);
        req  = r;
        prio = p;
        #1 check(grant, exp, tag);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Reset state: idle grant during reset (R8, R1).
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1 check(grant, 4'b0000, "R8 idle during reset");

        // Table walk, limit at maximum so no lane ages.
        do_reset(4'd15);
        for (int k = 0; k < 12; k++) begin
            string tag;
            case (VEC[k][21:20])
                2'd0: tag = "R1";
                2'd1: tag = "R2";
                2'd2: tag = "R3";
                default: tag = "R8";
            endcase
            step(VEC[k][19:16], VEC[k][15:4], VEC[k][3:0], $sformatf("%s row %0d", tag, k));
        end

        // R4: lane1 (level 0) against lane0 (level 7), limit 3: lane1 wins in cycle 3.
        do_reset(4'd3);
        for (int c = 0; c < 5; c++) begin
            step(4'b0011, {3'd0, 3'd0, 3'd0, 3'd7}, (c == 3) ? 4'b0010 : 4'b0001,
                 $sformatf("R4 aging cycle %0d", c));
        end

        // R6: a one-cycle drop restarts lane1's count.
        do_reset(4'd3);
        step(4'b0011, {3'd0, 3'd0, 3'd0, 3'd7}, 4'b0001, "R6 c0");
        step(4'b0011, {3'd0, 3'd0, 3'd0, 3'd7}, 4'b0001, "R6 c1");
        step(4'b0001, {3'd0, 3'd0, 3'd0, 3'd7}, 4'b0001, "R6 drop");
        step(4'b0011, {3'd0, 3'd0, 3'd0, 3'd7}, 4'b0001, "R6 c3");
        step(4'b0011, {3'd0, 3'd0, 3'd0, 3'd7}, 4'b0001, "R6 c4 no early age");
        step(4'b0011, {3'd0, 3'd0, 3'd0, 3'd7}, 4'b0001, "R6 c5");
        step(4'b0011, {3'd0, 3'd0, 3'd0, 3'd7}, 4'b0010, "R6 c6 aged");

        // R5: limit 0 ages every request; rotation ignores urgency.
        do_reset(4'd0);
        step(4'b0011, {3'd0, 3'd0, 3'd0, 3'd7}, 4'b0001, "R5 first");
        step(4'b0011, {3'd0, 3'd0, 3'd0, 3'd7}, 4'b0010, "R5 low level served");
        step(4'b0011, {3'd0, 3'd0, 3'd0, 3'd7}, 4'b0001, "R5 wrap");

        // R7: lanes 0,1 (level 0) age together at 15 against lane2 (level 7).
        do_reset(4'd15);
        for (int c = 0; c < 15; c++) begin
            step(4'b0111, {3'd0, 3'd7, 3'd0, 3'd0}, 4'b0100, "R4 urgent lane holds");
        end
        step(4'b0111, {3'd0, 3'd7, 3'd0, 3'd0}, 4'b0001, "R5 first aged");
        step(4'b0111, {3'd0, 3'd7, 3'd0, 3'd0}, 4'b0010, "R7 saturated lane stays aged");
        step(4'b0111, {3'd0, 3'd7, 3'd0, 3'd0}, 4'b0100, "R7 back to urgency");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule